// File: doc/BRIEF.md
# Flash ECC Wrapper with Write-Once Check Storage

This block sits between a 32-bit requester port and a word-organised flash-like data store. Each accepted word write is passed to the store together with an 8-bit check code, which the block computes and keeps in a private array that no address on the requester port reaches. On each read, the returned word is checked against its code. A single flipped data bit is repaired before the word reaches the requester. A double flip is reported and not repaired.

Check codes can be programmed once. A word can take a new value only after the sector that holds it has been erased. An erase command resets the data words of the sector and their check codes to all ones together. For this reason, writes must be whole, 4-byte-aligned words. A write that breaks either rule is refused and flagged, and nothing in storage changes. Only one command is taken per cycle, in the priority order erase, then write, then read.

The check code holds 6 Hamming bits in bits [5:0] and an overall parity bit in bit 6. Bit 7 is 0 once the code is programmed. An all-ones code (0xFF) marks a word whose code has never been programmed. Such words are returned raw.

Top module: `flash_ecc_wrapper`

## Requirements
- R1: An aligned write (address bits [1:0] = 0) to a word whose check code is erased drives `mem_wr` in the same cycle, with `mem_addr` = address bits [ADDR_W-1:2] and `mem_wdata` = `cpu_wdata`. A later read of that word returns the written value with both error pulses low.
- R2: `cpu_rvalid` is high in exactly the cycle after an accepted read, and in no other cycle.
- R3: A read of a programmed word with one flipped data bit, at any of the 32 positions, returns the originally written word with `cpu_corr` high for that one cycle.
- R4: A read of a programmed word with two flipped data bits raises `cpu_uncorr` and leaves `cpu_corr` low. The two pulses are never high together.
- R5: A write with address bits [1:0] not equal to 0 is refused: `mem_wr` stays low, `cpu_wr_err` is high in the next cycle, and the stored word keeps its old value.
- R6: A write to a word whose check code is already programmed is refused in the same way as in R5.
- R7: An erase of sector S, where S = address bits [ADDR_W-1:ADDR_W-SEC_W], returns the data and check codes of every word in S to all ones, so those words accept one new write. Words in other sectors stay programmed.
- R8: A read of a word whose check code is erased returns the raw stored data, including any flipped bits, with both error pulses low.
- R9: If several commands arrive in one cycle, erase wins over write, and write wins over read. Only the winning command has any effect.
- R10: A read ignores address bits [1:0] and returns the whole word at bits [ADDR_W-1:2].
- R11: While `rst_n` is low, `cpu_rvalid`, `cpu_corr`, `cpu_uncorr` and `cpu_wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Word write command |
| cpu_rd | input | 1 | Word read command |
| cpu_erase | input | 1 | Sector erase command |
| cpu_addr | input | ADDR_W | Byte address (the sector bits only are used for erase) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data after correction, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_corr | output | 1 | Single-bit error was corrected on this read |
| cpu_uncorr | output | 1 | Double-bit error detected on this read |
| cpu_wr_err | output | 1 | Previous-cycle write was refused |
| mem_wr | output | 1 | Program one data word in the store |
| mem_rd | output | 1 | Read one data word from the store (data on the next cycle) |
| mem_erase | output | 1 | Erase one sector of the store |
| mem_addr | output | ADDR_W-2 | Word index for store read or write |
| mem_sector | output | SEC_W | Sector index for store erase |
| mem_wdata | output | 32 | Data word to program |
| mem_rdata | input | 32 | Registered store read data |

## Verification
A check code that was stored or computed wrongly shows up on the first read of that word. The read data comes back one cycle after the request with `cpu_corr` or `cpu_uncorr` set although no bit was flipped, or with a flipped bit left unrepaired. A stale programmed or erased state in the check array shows up as the wrong outcome of the next write to that word: a good write refused with `cpu_wr_err` one cycle later, or a second write let through to `mem_wr` in the same cycle. A mistake in the erase sector selection shows when words in a neighbouring sector refuse, or accept, a fresh write after the erase.

// File: rtl/flash_ecc_pkg.sv
// Shared constants, command encoding and code functions for the flash ECC wrapper.
// Assumes 32-bit data words. The SEC-DED code places the data bits at the
// non-power-of-two positions 3..38 of a Hamming codeword.
package flash_ecc_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam logic [7:0] CHK_ERASED = 8'hFF;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_ERASE,
        CMD_WRITE,
        CMD_READ
    } cmd_e;

    // Codeword position of data bit idx (the idx-th position that is not a power of two).
    function automatic logic [HAM_W-1:0] data_pos(input int idx);
        int seen;
        logic [HAM_W-1:0] res;
        seen = 0;
        res  = '0;
        for (int p = 3; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) res = HAM_W'(p);
                seen++;
            end
        end
        return res;
    endfunction

    // Hamming bits: XOR of the codeword positions of all set data bits.
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) acc = acc ^ data_pos(i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
// Builds the 8-bit check code for one data word: Hamming bits in [5:0],
// overall parity in [6] (even over data and Hamming bits), and [7] = 0.
// Purely combinational; assumes the caller registers nothing here.
module ecc_encoder
    import flash_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [7:0]        chk_o
);

    logic [HAM_W-1:0] ham;

    // Hamming bits and overall parity of the incoming word.
    always_comb begin
        ham   = ham_bits(data_i);
        chk_o = {1'b0, ^{data_i, ham}, ham};
    end

endmodule

// File: rtl/ecc_decoder.sv
// Checks a fetched word against its stored code and repairs a single flipped
// data bit. An erased code (0xFF) bypasses checking. Assumes only one flag is
// meaningful per read; flags are qualified by the caller.
module ecc_decoder
    import flash_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] raw_i,
    input  logic [7:0]        chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              uncorr_o
);

    logic [HAM_W-1:0]  syn;
    logic              odd;
    logic [DATA_W-1:0] flip;

    // Syndrome and overall parity over data plus stored code.
    always_comb begin
        syn = ham_bits(raw_i) ^ chk_i[HAM_W-1:0];
        odd = ^{raw_i, chk_i[HAM_W:0]};
    end

    // One comparator per data bit selects the bit named by the syndrome.
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [HAM_W-1:0] POS = data_pos(i);
        assign flip[i] = (syn == POS);
    end

    // Classify and repair.
    always_comb begin
        data_o   = raw_i;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        if (chk_i != CHK_ERASED) begin
            if (odd) begin
                corr_o = 1'b1;
                data_o = raw_i ^ flip;
            end else if (syn != '0) begin
                uncorr_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/check_store.sv
// Private array of check codes, one per data word, grouped in sectors.
// Models non-volatile cells, so it has no reset. An erase writes 0xFF to every
// code of one sector; program writes one code. Lookup is combinational.
// Assumes the caller never programs and erases in the same cycle.
module check_store #(
    parameter int WORDS        = 64,
    parameter int SECTOR_WORDS = 16,
    localparam int IDX_W       = $clog2(WORDS),
    localparam int SEC_W       = IDX_W - $clog2(SECTOR_WORDS)
) (
    input  logic             clk,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [7:0]       prog_val,
    input  logic             erase_en,
    input  logic [SEC_W-1:0] erase_sec,
    input  logic [IDX_W-1:0] look_idx,
    output logic [7:0]       look_val
);

    logic [7:0] cells [WORDS];

    // Sector erase or single-code program.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (erase_en && (w / SECTOR_WORDS) == int'(erase_sec)) begin
                cells[w] <= 8'hFF;
            end else if (prog_en && int'(prog_idx) == w) begin
                cells[w] <= prog_val;
            end
        end
    end

    // Lookup of the code addressed by the current command.
    assign look_val = cells[look_idx];

endmodule

// File: rtl/flash_ecc_wrapper.sv
// Top of the flash ECC wrapper. Decodes one command per cycle (erase > write
// > read), keeps write-once check codes in a private store, and returns
// corrected read data one cycle after the request. Assumes the data store
// answers mem_rd with registered data on the next cycle.
module flash_ecc_wrapper
    import flash_ecc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int SECTOR_WORDS = 16,
    localparam int IDX_W       = ADDR_W - 2,
    localparam int WORDS       = 1 << IDX_W,
    localparam int SEC_W       = IDX_W - $clog2(SECTOR_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_erase,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_corr,
    output logic              cpu_uncorr,
    output logic              cpu_wr_err,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              mem_erase,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [SEC_W-1:0]  mem_sector,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    cmd_e              cmd;
    logic [IDX_W-1:0]  widx;
    logic [SEC_W-1:0]  sidx;
    logic [7:0]        look_val;
    logic [7:0]        enc_chk;
    logic              wr_ok;
    logic              rvalid_q;
    logic              wr_err_q;
    logic [7:0]        chk_q;
    logic              dec_corr;
    logic              dec_uncorr;

    assign widx = cpu_addr[ADDR_W-1:2];
    assign sidx = cpu_addr[ADDR_W-1 -: SEC_W];

    // Pick the single command served this cycle.
    always_comb begin
        if (cpu_erase)   cmd = CMD_ERASE;
        else if (cpu_wr) cmd = CMD_WRITE;
        else if (cpu_rd) cmd = CMD_READ;
        else             cmd = CMD_IDLE;
    end

    // A write goes ahead only when aligned and its code is still erased.
    assign wr_ok = (cmd == CMD_WRITE) && (cpu_addr[1:0] == 2'b00)
                   && (look_val == CHK_ERASED);

    ecc_encoder u_enc (
        .data_i (cpu_wdata),
        .chk_o  (enc_chk)
    );

    check_store #(
        .WORDS        (WORDS),
        .SECTOR_WORDS (SECTOR_WORDS)
    ) u_store (
        .clk       (clk),
        .prog_en   (wr_ok),
        .prog_idx  (widx),
        .prog_val  (enc_chk),
        .erase_en  (cmd == CMD_ERASE),
        .erase_sec (sidx),
        .look_idx  (widx),
        .look_val  (look_val)
    );

    // Data-store command outputs.
    assign mem_wr     = wr_ok;
    assign mem_rd     = (cmd == CMD_READ);
    assign mem_erase  = (cmd == CMD_ERASE);
    assign mem_addr   = widx;
    assign mem_sector = sidx;
    assign mem_wdata  = cpu_wdata;

    // Read-valid, refused-write flag and the code travelling with a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            wr_err_q <= 1'b0;
            chk_q    <= CHK_ERASED;
        end else begin
            rvalid_q <= (cmd == CMD_READ);
            wr_err_q <= (cmd == CMD_WRITE) && !wr_ok;
            if (cmd == CMD_READ) chk_q <= look_val;
        end
    end

    ecc_decoder u_dec (
        .raw_i    (mem_rdata),
        .chk_i    (chk_q),
        .data_o   (cpu_rdata),
        .corr_o   (dec_corr),
        .uncorr_o (dec_uncorr)
    );

    // Qualified read-side outputs.
    assign cpu_rvalid = rvalid_q;
    assign cpu_corr   = rvalid_q & dec_corr;
    assign cpu_uncorr = rvalid_q & dec_uncorr;
    assign cpu_wr_err = wr_err_q;

endmodule

// File: rtl/flash_ecc_wrapper_chk.sv
// Port-level properties of the flash ECC wrapper, bound to every instance.
module flash_ecc_wrapper_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic              cpu_erase,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rvalid,
    input logic              cpu_corr,
    input logic              cpu_uncorr,
    input logic              cpu_wr_err,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              mem_erase
);

    logic rd_taken;
    logic wr_taken;
    assign rd_taken = cpu_rd && !cpu_wr && !cpu_erase;
    assign wr_taken = cpu_wr && !cpu_erase;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_taken |=> cpu_rvalid); // R2
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n) !rd_taken |=> !cpu_rvalid); // R2
    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n) (cpu_corr || cpu_uncorr) |-> cpu_rvalid); // R3
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cpu_corr && cpu_uncorr)); // R4
    AST_MISALIGNED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (wr_taken && cpu_addr[1:0] != 2'b00) |-> !mem_wr); // R5
    AST_MISALIGNED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (wr_taken && cpu_addr[1:0] != 2'b00) |=> cpu_wr_err); // R5
    AST_WR_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cpu_wr_err |-> $past(wr_taken)); // R6
    AST_REFUSED_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !cpu_wr_err); // R6
    AST_ERASE_WINS: assert property (@(posedge clk) disable iff (!rst_n) cpu_erase |-> (mem_erase && !mem_wr && !mem_rd)); // R9
    AST_WRITE_OVER_READ: assert property (@(posedge clk) disable iff (!rst_n) wr_taken |-> !mem_rd); // R9

endmodule

bind flash_ecc_wrapper flash_ecc_wrapper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_erase  (cpu_erase),
    .cpu_addr   (cpu_addr),
    .cpu_rvalid (cpu_rvalid),
    .cpu_corr   (cpu_corr),
    .cpu_uncorr (cpu_uncorr),
    .cpu_wr_err (cpu_wr_err),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_erase  (mem_erase)
);

// File: tb/flash_ecc_wrapper_tb.sv
`timescale 1ns/1ps
// Bench: behavioural data store, behavioural reference model, per-clock compare.
module flash_ecc_wrapper_tb;

    localparam int ADDR_W = 8;
    localparam int SECW   = 16;
    localparam int NW     = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_erase = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_rvalid, cpu_corr, cpu_uncorr, cpu_wr_err;
    logic        mem_wr, mem_rd, mem_erase;
    logic [5:0]  mem_addr;
    logic [1:0]  mem_sector;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic        inj_en = 1'b0;
    int          inj_w = 0, inj_b = 0;

    always #2.5 clk = ~clk;

    flash_ecc_wrapper #(.ADDR_W(ADDR_W), .SECTOR_WORDS(SECW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_erase(cpu_erase), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_corr(cpu_corr),
        .cpu_uncorr(cpu_uncorr), .cpu_wr_err(cpu_wr_err), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_erase(mem_erase), .mem_addr(mem_addr),
        .mem_sector(mem_sector), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Data store model, including bit-flip injection.
    logic [31:0] store [NW];
    always @(posedge clk) begin
        if (inj_en) store[inj_w][inj_b] <= ~store[inj_w][inj_b];
        if (mem_erase)
            for (int k = 0; k < NW; k++)
                if (k / SECW == int'(mem_sector)) store[k] <= '1;
        if (mem_wr) store[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= store[mem_addr];
    end

    // Reference model of the requirements.
    logic [31:0] gold [NW];
    logic [31:0] fmask [NW];
    bit          prog [NW];
    logic        e_rv = 0, e_err = 0, e_corr = 0, e_unc = 0, e_dchk = 0;
    logic [31:0] e_data = '0;
    int          mw, nflip;
    always @(posedge clk) begin
        if (!rst_n) begin
            e_rv <= 0; e_err <= 0; e_corr <= 0; e_unc <= 0; e_dchk <= 0;
        end else begin
            e_rv <= 0; e_err <= 0; e_corr <= 0; e_unc <= 0; e_dchk <= 0;
            if (inj_en) fmask[inj_w][inj_b] = ~fmask[inj_w][inj_b];
            mw = int'(cpu_addr) / 4;
            if (cpu_erase) begin
                for (int k = 0; k < NW; k++)
                    if (k / SECW == mw / SECW) begin
                        prog[k] = 0; fmask[k] = '0; gold[k] = '1;
                    end
            end else if (cpu_wr) begin
                if (cpu_addr[1:0] != 2'b00 || prog[mw]) e_err <= 1;
                else begin prog[mw] = 1; gold[mw] = cpu_wdata; fmask[mw] = '0; end
            end else if (cpu_rd) begin
                e_rv <= 1;
                nflip = $countones(fmask[mw]);
                if (!prog[mw]) begin e_data <= store[mw]; e_dchk <= 1; end
                else if (nflip <= 1) begin
                    e_data <= gold[mw]; e_dchk <= 1; e_corr <= (nflip == 1);
                end else e_unc <= 1;
            end
        end
    end

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R11";

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model after each edge settles.
    always @(posedge clk) begin
        #1;
        check(cpu_rvalid === e_rv, (cur_req == "R11") ? "R11" : "R2", 32'(cpu_rvalid), 32'(e_rv));
        check(cpu_wr_err === e_err, cur_req, 32'(cpu_wr_err), 32'(e_err));
        check(cpu_corr === e_corr, cur_req, 32'(cpu_corr), 32'(e_corr));
        check(cpu_uncorr === e_unc, cur_req, 32'(cpu_uncorr), 32'(e_unc));
        if (e_dchk) check(cpu_rdata === e_data, cur_req, cpu_rdata, e_data);
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL WATCHDOG: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic cmd(input bit e, input bit w, input bit r, input int a, input logic [31:0] d);
        @(negedge clk);
        cpu_erase = e; cpu_wr = w; cpu_rd = r; cpu_addr = 8'(a); cpu_wdata = d;
        @(negedge clk);
        cpu_erase = 0; cpu_wr = 0; cpu_rd = 0;
    endtask

    task automatic inject(input int w, input int b);
        @(negedge clk);
        inj_en = 1; inj_w = w; inj_b = b;
        @(negedge clk);
        inj_en = 0;
    endtask

    initial begin
        for (int k = 0; k < NW; k++) begin gold[k] = '1; fmask[k] = '0; prog[k] = 0; store[k] = '1; end
        cur_req = "R11";
        repeat (4) @(negedge clk);
        check(cpu_rvalid === 0 && cpu_wr_err === 0 && cpu_corr === 0 && cpu_uncorr === 0,
              "R11", {28'd0, cpu_rvalid, cpu_wr_err, cpu_corr, cpu_uncorr}, 32'd0);
        rst_n = 1;
        cur_req = "R7";
        for (int s = 0; s < NW / SECW; s++) cmd(1, 0, 0, s * SECW * 4, 0);
        // R8: erased words come back raw, even when corrupted.
        cur_req = "R8";
        cmd(0, 0, 1, 5 * 4, 0);
        inject(5, 3);
        cmd(0, 0, 1, 5 * 4, 0);
        // R1: program and read back several patterns.
        cur_req = "R1";
        for (int i = 0; i < 16; i++) cmd(0, 1, 0, i * 4, 32'h1234_5678 ^ (32'(i) * 32'h9E37_79B9));
        cmd(0, 1, 0, 17 * 4, 32'h0000_0000);
        cmd(0, 1, 0, 18 * 4, 32'hFFFF_FFFF);
        for (int i = 0; i < 19; i++) cmd(0, 0, 1, i * 4, 0);
        // R3: every single-bit position.
        cur_req = "R3";
        for (int b = 0; b < 32; b++) begin
            inject(1, b);
            cmd(0, 0, 1, 4, 0);
            inject(1, b);
            cmd(0, 0, 1, 4, 0);
        end
        inject(17, 0); cmd(0, 0, 1, 17 * 4, 0); inject(17, 0);
        // R4: double flips.
        cur_req = "R4";
        inject(2, 0); inject(2, 31); cmd(0, 0, 1, 8, 0);
        inject(2, 0); inject(2, 31);
        inject(18, 5); inject(18, 6); cmd(0, 0, 1, 18 * 4, 0);
        inject(18, 5); inject(18, 6);
        // R5: misaligned write refused, storage untouched.
        cur_req = "R5";
        cmd(0, 1, 0, 20 * 4 + 1, 32'hDEAD_BEEF);
        cmd(0, 0, 1, 20 * 4, 0);
        cmd(0, 1, 0, 8 * 4 + 2, 32'hCAFE_F00D);
        cmd(0, 0, 1, 8 * 4, 0);
        // R6: second write to a programmed word refused.
        cur_req = "R6";
        cmd(0, 1, 0, 3 * 4, 32'hA5A5_5A5A);
        cmd(0, 0, 1, 3 * 4, 0);
        // R7: sector erase frees its words only.
        cur_req = "R7";
        cmd(1, 0, 0, 0, 0);
        cmd(0, 0, 1, 3 * 4, 0);
        cmd(0, 1, 0, 3 * 4, 32'h0BAD_F00D);
        cmd(0, 0, 1, 3 * 4, 0);
        cmd(0, 1, 0, 17 * 4, 32'h7777_7777);
        cmd(0, 0, 1, 17 * 4, 0);
        // R9: command priority.
        cur_req = "R9";
        cmd(0, 1, 0, 32 * 4, 32'h1111_2222);
        cmd(1, 1, 1, 32 * 4, 32'h3333_4444);
        cmd(0, 0, 1, 32 * 4, 0);
        cmd(0, 1, 1, 33 * 4, 32'h5555_6666);
        cmd(0, 0, 1, 33 * 4, 0);
        // R10: low address bits ignored on read.
        cur_req = "R10";
        cmd(0, 0, 1, 33 * 4 + 3, 0);
        cmd(0, 0, 1, 7 * 4 + 1, 0);
        cur_req = "R2";
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule